// File: doc/BRIEF.md
# Program ROM Bank Switching Register File

This block sits on the CPU write path of a cartridge mapper. It watches CPU writes into the upper half of the address space and keeps a small set of registers. From those registers it produces the 8 KB program-memory bank numbers for the four CPU windows at 0x8000, 0xA000, 0xC000 and 0xE000, and a nametable mirroring select.

Register access is indirect. A write to the index port chooses a register slot, and a later write to the data port loads that slot. Slot 6 loads the bank for the first window and slot 7 loads the bank for the second window. Slot 0 loads a one-bit outer-bank select. That select places a 512 KB half of the ROM over all four windows, including the two upper windows, which otherwise point at banks 0x3E and 0x3F. Address bit 11 is not decoded, so each port also answers 0x0800 higher.

Top module: `prg_bank_regfile`

## Requirements
- R1: After reset the four windows show banks 0, 1, 0x3E and 0x3F, in window order 0x8000, 0xA000, 0xC000, 0xE000. The mirroring output is 0, meaning vertical.
- R2: Address bit 11 is not decoded. Writes to 0x8800, 0x8801 and 0xA800 act exactly like writes to 0x8000, 0x8001 and 0xA000.
- R3: A write to 0x8000 stores the data byte as the index. A following write to 0x8001 while the index is 6 makes that byte, ORed with the outer value, the bank of the 0x8000 window.
- R4: A write to 0x8001 while the index is 7 makes the data byte, ORed with the outer value, the bank of the 0xA000 window.
- R5: A write to 0x8001 while the index is 0 sets the outer value from data bit 1. Bit 1 set gives 0x40 and bit 1 clear gives 0x00. The outer value is ORed into the bank number of all four windows.
- R6: The 0xC000 window always shows 0x3E ORed with the outer value. The 0xE000 window always shows 0x3F ORed with the outer value.
- R7: A write to 0xA000 sets the mirroring output from data bit 0. A value of 1 selects horizontal and 0 selects vertical.
- R8: While the four_screen input is high, writes to 0xA000 leave the mirroring output unchanged.
- R9: The following writes change no output: writes to 0xA001, 0xC000, 0xC001, 0xE000 and 0xE001; writes below 0x8000; and data-port writes while the index is any value other than 0, 6 or 7.
- R10: Each output bank number is the low BANK_W bits of the stored value ORed with the outer value. With the default BANK_W of 7, a stored 0xFF reads out as 0x7F.
- R11: Every update takes effect on the rising clock edge that samples cpu_we high. While cpu_we is low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | DATA_W | CPU write data |
| cpu_we | input | 1 | Write strobe, sampled on the rising edge |
| four_screen | input | 1 | Strap that freezes the mirroring select |
| bank_w0 | output | BANK_W | Bank number for the 0x8000 window |
| bank_w1 | output | BANK_W | Bank number for the 0xA000 window |
| bank_w2 | output | BANK_W | Bank number for the 0xC000 window |
| bank_w3 | output | BANK_W | Bank number for the 0xE000 window |
| mirror_horiz | output | 1 | 1 selects horizontal mirroring, 0 selects vertical |

## Verification
Every stored register drives a port through logic with no further registers, so any error in a bank register or the outer select shows on the bank outputs in the cycle after the write that caused it. An outer select held at the wrong value shows on all four windows at once.

A wrong index is harder to see. It stays hidden until the next data-port write, which then lands in the wrong slot or is dropped. For that reason the stimulus keeps interleaving index writes and data writes, and compares every output after every write.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;

   typedef enum logic [1:0] {
      CMD_NONE   = 2'd0,
      CMD_INDEX  = 2'd1,
      CMD_DATA   = 2'd2,
      CMD_MIRROR = 2'd3
   } wr_cmd_t;

   localparam logic [15:0] PORT_INDEX  = 16'h8000;
   localparam logic [15:0] PORT_DATA   = 16'h8001;
   localparam logic [15:0] PORT_MIRROR = 16'hA000;
   localparam logic [15:0] ALIAS_MASK  = 16'hF7FF;

   localparam int SLOT_OUTER = 0;
   localparam int SLOT_WIN0  = 6;
   localparam int SLOT_WIN1  = 7;

   localparam int OUTER_SRC_BIT = 1;
   localparam int OUTER_DST_BIT = 6;
   localparam int FIXED_BASE    = 'h3E;

endpackage

// File: rtl/prg_wr_decode.sv
module prg_wr_decode
   import prg_bank_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   output wr_cmd_t           cmd
);

   if (ADDR_W != 16) begin : g_bad_addr
      $error("prg_wr_decode: ADDR_W must be 16");
   end

   logic [15:0] folded;
   assign folded = addr[15:0] & ALIAS_MASK;

   always_comb begin
      cmd = CMD_NONE;
      if (we) begin
         unique case (folded)
            PORT_INDEX:  cmd = CMD_INDEX;
            PORT_DATA:   cmd = CMD_DATA;
            PORT_MIRROR: cmd = CMD_MIRROR;
            default:     cmd = CMD_NONE;
         endcase
      end
   end

endmodule

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
   import prg_bank_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wr_cmd_t           cmd,
   input  logic [DATA_W-1:0] data,
   input  logic              four_screen,
   output logic [DATA_W-1:0] prg_lo,
   output logic [DATA_W-1:0] prg_hi,
   output logic [DATA_W-1:0] outer,
   output logic              mirror
);

   if (DATA_W <= OUTER_DST_BIT) begin : g_bad_data
      $error("prg_bank_regs: DATA_W too narrow for outer bit");
   end

   localparam logic [DATA_W-1:0] SLOT0 = DATA_W'(SLOT_OUTER);
   localparam logic [DATA_W-1:0] SLOT6 = DATA_W'(SLOT_WIN0);
   localparam logic [DATA_W-1:0] SLOT7 = DATA_W'(SLOT_WIN1);

   logic [DATA_W-1:0] index_q;
   logic [DATA_W-1:0] outer_nx;

   always_comb begin
      outer_nx = '0;
      outer_nx[OUTER_DST_BIT] = data[OUTER_SRC_BIT];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         index_q <= '0;
         prg_lo  <= DATA_W'(0);
         prg_hi  <= DATA_W'(1);
         outer   <= '0;
         mirror  <= 1'b0;
      end else begin
         case (cmd)
            CMD_INDEX: index_q <= data;
            CMD_DATA: begin
               if (index_q == SLOT0) outer  <= outer_nx;
               if (index_q == SLOT6) prg_lo <= data;
               if (index_q == SLOT7) prg_hi <= data;
            end
            CMD_MIRROR: if (!four_screen) mirror <= data[0];
            default: ;
         endcase
      end
   end

   // R3
   index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_INDEX |=> index_q == $past(data));

   // R8
   mirror_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      four_screen |=> $stable(mirror));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == CMD_NONE |=> ($stable(prg_lo) && $stable(prg_hi) && $stable(outer)
                           && $stable(mirror) && $stable(index_q)));

   // R5
   outer_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(outer) <= 1 && (outer == '0 || outer[OUTER_DST_BIT]));

endmodule

// File: rtl/prg_bank_map.sv
module prg_bank_map
   import prg_bank_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int BANK_W = 7,
   parameter int N_WIN  = 4
) (
   input  logic [DATA_W-1:0]             prg_lo,
   input  logic [DATA_W-1:0]             prg_hi,
   input  logic [DATA_W-1:0]             outer,
   output logic [N_WIN-1:0][BANK_W-1:0]  win
);

   if (BANK_W < 1 || BANK_W > DATA_W) begin : g_bad_bank
      $error("prg_bank_map: BANK_W must be 1..DATA_W");
   end
   if (N_WIN != 4) begin : g_bad_win
      $error("prg_bank_map: N_WIN must be 4");
   end

   for (genvar w = 0; w < N_WIN; w++) begin : g_win
      logic [DATA_W-1:0] src;
      logic [DATA_W-1:0] full;
      if (w == 0) begin : g_sw0
         assign src = prg_lo;
      end else if (w == 1) begin : g_sw1
         assign src = prg_hi;
      end else begin : g_fix
         localparam logic [DATA_W-1:0] FIX = DATA_W'(FIXED_BASE + w - 2);
         assign src = FIX;
      end
      assign full   = src | outer;
      assign win[w] = full[BANK_W-1:0];
   end

endmodule

// File: rtl/prg_bank_regfile.sv
module prg_bank_regfile
   import prg_bank_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int BANK_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              cpu_we,
   input  logic              four_screen,
   output logic [BANK_W-1:0] bank_w0,
   output logic [BANK_W-1:0] bank_w1,
   output logic [BANK_W-1:0] bank_w2,
   output logic [BANK_W-1:0] bank_w3,
   output logic              mirror_horiz
);

   localparam int N_WIN = 4;

   wr_cmd_t                      cmd;
   logic [DATA_W-1:0]            prg_lo, prg_hi, outer;
   logic [N_WIN-1:0][BANK_W-1:0] win;

   prg_wr_decode #(.ADDR_W(16)) u_dec (
      .addr(cpu_addr), .we(cpu_we), .cmd(cmd)
   );

   prg_bank_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .data(cpu_data),
      .four_screen(four_screen), .prg_lo(prg_lo), .prg_hi(prg_hi),
      .outer(outer), .mirror(mirror_horiz)
   );

   prg_bank_map #(.DATA_W(DATA_W), .BANK_W(BANK_W), .N_WIN(N_WIN)) u_map (
      .prg_lo(prg_lo), .prg_hi(prg_hi), .outer(outer), .win(win)
   );

   assign bank_w0 = win[0];
   assign bank_w1 = win[1];
   assign bank_w2 = win[2];
   assign bank_w3 = win[3];

   // R6
   fixed_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_w2[0] == 1'b0 || BANK_W == 0) && (bank_w3 == (bank_w2 | BANK_W'(1))));

   // R9
   ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && !cpu_addr[15]) |=> ($stable(bank_w0) && $stable(bank_w1)
                                      && $stable(bank_w3) && $stable(mirror_horiz)));

endmodule

// File: tb/prg_bank_regfile_test.sv
module prg_bank_regfile_test;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W = 8;
   localparam int BANK_W = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [15:0]       cpu_addr = '0;
   logic [DATA_W-1:0] cpu_data = '0;
   logic              cpu_we = 1'b0;
   logic              four_screen = 1'b0;
   logic [BANK_W-1:0] bank_w0, bank_w1, bank_w2, bank_w3;
   logic              mirror_horiz;

   int n_tests = 0;
   int n_fail  = 0;

   logic [7:0] m_idx, m_p0, m_p1, m_outer;
   logic       m_mir;

   always #(CLK_PERIOD/2) clk = ~clk;

   prg_bank_regfile #(.DATA_W(DATA_W), .BANK_W(BANK_W)) uut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_we(cpu_we), .four_screen(four_screen), .bank_w0(bank_w0),
      .bank_w1(bank_w1), .bank_w2(bank_w2), .bank_w3(bank_w3),
      .mirror_horiz(mirror_horiz)
   );

   function automatic logic [BANK_W-1:0] exp_bank(input logic [7:0] v, input logic [7:0] o);
      logic [7:0] t;
      t = v | o;
      return t[BANK_W-1:0];
   endfunction

   function automatic void model_reset();
      m_idx = 8'h00; m_p0 = 8'h00; m_p1 = 8'h01; m_outer = 8'h00; m_mir = 1'b0;
   endfunction

   function automatic void model_write(input logic [15:0] a, input logic [7:0] d, input logic fs);
      logic [15:0] f;
      f = a & 16'hF7FF;
      if (f == 16'h8000) m_idx = d;
      else if (f == 16'h8001) begin
         if (m_idx == 8'd0) m_outer = d[1] ? 8'h40 : 8'h00;
         else if (m_idx == 8'd6) m_p0 = d;
         else if (m_idx == 8'd7) m_p1 = d;
      end else if (f == 16'hA000 && !fs) m_mir = d[0];
   endfunction

   task automatic check_one(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      check_one(req, "w0", int'(bank_w0), int'(exp_bank(m_p0, m_outer)));
      check_one(req, "w1", int'(bank_w1), int'(exp_bank(m_p1, m_outer)));
      check_one(req, "w2", int'(bank_w2), int'(exp_bank(8'h3E, m_outer)));
      check_one(req, "w3", int'(bank_w3), int'(exp_bank(8'h3F, m_outer)));
      check_one(req, "mirror", int'(mirror_horiz), int'(m_mir));
   endtask

   // drive at negedge, strobe sampled on next posedge, check at following negedge
   task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
      cpu_addr = a; cpu_data = d; cpu_we = 1'b1;
      @(negedge clk);
      cpu_we = 1'b0;
      model_write(a, d, four_screen);
      check_all(req);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_tests++; n_fail++;
      $display("FAIL R11 watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_one("R1", "w0", int'(bank_w0), 0);
      check_one("R1", "w1", int'(bank_w1), 1);
      check_one("R1", "w2", int'(bank_w2), 'h3E);
      check_one("R1", "w3", int'(bank_w3), 'h3F);
      check_one("R1", "mirror", int'(mirror_horiz), 0);

      // R3 / R4 directed
      wr(16'h8000, 8'h06, "R3"); wr(16'h8001, 8'h12, "R3");
      check_one("R3", "w0 direct", int'(bank_w0), 'h12);
      wr(16'h8000, 8'h07, "R4"); wr(16'h8001, 8'h25, "R4");
      check_one("R4", "w1 direct", int'(bank_w1), 'h25);
      // R5 / R6 outer half
      wr(16'h8000, 8'h00, "R5"); wr(16'h8001, 8'h02, "R5");
      check_one("R5", "w0 outer", int'(bank_w0), 'h52);
      check_one("R6", "w2 outer", int'(bank_w2), 'h7E);
      check_one("R6", "w3 outer", int'(bank_w3), 'h7F);
      wr(16'h8001, 8'hFD, "R5");
      check_one("R5", "outer clear", int'(bank_w3), 'h3F);
      // R10 masking
      wr(16'h8000, 8'h06, "R10"); wr(16'h8001, 8'hFF, "R10");
      check_one("R10", "w0 mask", int'(bank_w0), 'h7F);
      // R2 alias
      wr(16'h8800, 8'h07, "R2"); wr(16'h8801, 8'h0C, "R2");
      check_one("R2", "alias w1", int'(bank_w1), 'h0C);
      wr(16'hA800, 8'h01, "R2");
      // R7 mirror
      wr(16'hA000, 8'h01, "R7");
      check_one("R7", "horiz", int'(mirror_horiz), 1);
      wr(16'hA000, 8'h00, "R7");
      check_one("R7", "vert", int'(mirror_horiz), 0);
      // R8 strap
      four_screen = 1'b1;
      wr(16'hA000, 8'h01, "R8");
      check_one("R8", "held", int'(mirror_horiz), 0);
      four_screen = 1'b0;
      // R9 ignored writes
      wr(16'hA001, 8'hFF, "R9"); wr(16'hC000, 8'hFF, "R9");
      wr(16'hC001, 8'hFF, "R9"); wr(16'hE000, 8'hFF, "R9");
      wr(16'hE001, 8'hFF, "R9"); wr(16'h0001, 8'h02, "R9");
      wr(16'h7FFF, 8'h03, "R9");
      wr(16'h8000, 8'h03, "R9"); wr(16'h8001, 8'h02, "R9");
      wr(16'h8000, 8'h86, "R9"); wr(16'h8001, 8'h55, "R9");
      // R11 strobe low: nothing moves
      for (int i = 0; i < 20; i++) begin
         cpu_addr = 16'h8000 | 16'($urandom_range(0, 1)); cpu_data = 8'($urandom);
         @(negedge clk);
         check_all("R11");
      end
      // random mix
      for (int i = 0; i < 600; i++) begin
         logic [15:0] a;
         logic [7:0]  d;
         int sel;
         sel = $urandom_range(0, 9);
         case (sel)
            0, 1: begin a = 16'h8000; d = 8'($urandom_range(0, 8)); if (d == 8) d = 8'($urandom); end
            2, 3, 4: a = 16'h8001;
            5: a = 16'h8800 | 16'($urandom_range(0, 1));
            6: a = 16'hA000 | 16'($urandom_range(0, 1) << 11);
            7: a = 16'hA001;
            8: a = 16'hC000 | 16'($urandom_range(0, 1)) | 16'($urandom_range(0, 1) << 13);
            default: a = 16'($urandom);
         endcase
         if (sel > 1) d = 8'($urandom);
         four_screen = ($urandom_range(0, 7) == 0);
         wr(a, d, "R11");
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule